// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block keeps one 8-bit urgency value per interrupt line and picks, each cycle, the most urgent line that is both pending and enabled. A smaller number means more urgent. The values are reached through a word-wide port: every 32-bit word carries four values, one per line, for four neighbouring lines. A parameter sets how many of the eight bits exist in hardware. The bits that exist are the upper ones. The bits that do not exist always read back as zero.

A 3-bit split setting, held in a control word, divides each value into an upper preemption part and a lower ordering part. The winner among pending lines is chosen on the full value. Whether that winner may interrupt the code that is running now depends only on the preemption part, compared against the priority of the active context. A preemption part that is only equal never preempts. All arbitration results come out of registers, one cycle after their inputs.

Top module: `grp_prio_arbiter`

## Requirements
- R1: After synchronous reset, every stored value reads as zero, the split setting is 0, and win_valid and win_preempt are low.
- R2: In word address k, the bits [8j+7:8j] (j = 0..3) hold the value of line 4k+j. A write replaces all four values, and a read returns them combinationally.
- R3: With IMPL_BITS bits present, bits [7-IMPL_BITS:0] of every value read as zero whatever was written.
- R4: Value slots for line numbers at or above NUM_LINES read as zero, and writes to them change nothing.
- R5: Bits [10:8] of the control write port set the split setting g. The control read port returns g in bits [10:8] and zero in all other bits.
- R6: The winner is the line with pend and enable both high that has the lowest stored value. When values are equal, the lowest line number wins. win_prio gives the stored value.
- R7: A line with pend or enable low never wins. When no line qualifies, win_valid, win_idx, win_prio and win_preempt are all zero.
- R8: When act_valid is high, win_preempt is high only if the winner's bits [7:g+1] form a value strictly below the same bits of act_prio. Equal parts never preempt, and for g = 7 win_preempt stays low.
- R9: When act_valid is low, win_preempt equals win_valid.
- R10: The arbitration outputs show the inputs and stored state as sampled at the previous rising clock edge, and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_wr_en | input | 1 | Write strobe for a word of four values |
| prio_wr_addr | input | ADDR_W | Word address for writes |
| prio_wr_data | input | 32 | Four values for the write |
| prio_rd_addr | input | ADDR_W | Word address for reads |
| prio_rd_data | output | 32 | Four values at the read address |
| ctrl_wr_en | input | 1 | Write strobe for the control word |
| ctrl_wr_data | input | 32 | Control word, split setting in [10:8] |
| ctrl_rd_data | output | 32 | Control word readback |
| irq_pend | input | NUM_LINES | Pending flag per line |
| irq_en | input | NUM_LINES | Enable flag per line |
| act_valid | input | 1 | An active context exists |
| act_prio | input | 8 | Priority of the active context |
| win_valid | output | 1 | A qualifying line was found |
| win_idx | output | IDX_W | Winning line number |
| win_prio | output | 8 | Stored value of the winner |
| win_preempt | output | 1 | Winner may preempt the active context |

## Verification
A stored value that is wrong shows up as a readback difference in the same cycle. It also shows up as a wrong winner, or a wrong preempt decision, one edge after that line is made to compete. A corrupted split setting would show on the control readback at once. It would also change win_preempt for winners and actives that differ only below the true split. For that reason the random stimulus runs over all eight settings with preemption parts that are close to equal. Ordering faults, such as ties broken the wrong way or disabled lines winning, show on win_idx one cycle after the request pattern is applied.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    typedef logic [7:0] prio_t;
    typedef logic [2:0] split_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
        prio_t      prio;
    } cand_t;

    // Mask of the bits that exist when 'bits' upper bits are implemented
    function automatic prio_t impl_mask(input int bits);
        prio_t m;
        for (int b = 0; b < 8; b++) begin
            m[b] = (b >= 8 - bits);
        end
        return m;
    endfunction

    // Mask of the preemption part for split setting g: bits [7:g+1]
    function automatic prio_t group_mask(input split_t g);
        prio_t m;
        for (int b = 0; b < 8; b++) begin
            m[b] = (b > int'(g));
        end
        return m;
    endfunction

endpackage

// File: rtl/prio_field_bank.sv
module prio_field_bank
    import prio_arb_pkg::*;
#(
    parameter int NUM_LINES = 10,
    parameter int IMPL_BITS = 5,
    parameter int ADDR_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [31:0]                   rd_data,
    output logic [NUM_LINES-1:0][7:0]     fields
);

    localparam prio_t IMASK = impl_mask(IMPL_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (wr_addr == ADDR_W'(i / 4)) begin
                    fields[i] <= wr_data[8*(i%4) +: 8] & IMASK;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_addr == ADDR_W'(i / 4)) begin
                rd_data[8*(i%4) +: 8] = fields[i];
            end
        end
    end

    // R3
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~{4{IMASK}}) == 32'd0);

endmodule

// File: rtl/prio_min_select.sv
module prio_min_select
    import prio_arb_pkg::*;
#(
    parameter int NUM_LINES = 10
) (
    input  logic [NUM_LINES-1:0]          req,
    input  logic [NUM_LINES-1:0][7:0]     fields,
    output cand_t                         best
);

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req[i] && (!best.hit || fields[i] < best.prio)) begin
                best.hit  = 1'b1;
                best.idx  = 8'(i);
                best.prio = fields[i];
            end
        end
    end

endmodule

// File: rtl/prio_preempt_cmp.sv
module prio_preempt_cmp
    import prio_arb_pkg::*;
(
    input  cand_t  cand,
    input  split_t split,
    input  logic   act_valid,
    input  prio_t  act_prio,
    output logic   preempt
);

    prio_t gmask;

    always_comb begin
        gmask = group_mask(split);
        if (!cand.hit) begin
            preempt = 1'b0;
        end else if (!act_valid) begin
            preempt = 1'b1;
        end else begin
            preempt = (cand.prio & gmask) < (act_prio & gmask);
        end
    end

endmodule

// File: rtl/grp_prio_arbiter.sv
module grp_prio_arbiter
    import prio_arb_pkg::*;
#(
    parameter int NUM_LINES = 10,
    parameter int IMPL_BITS = 5,
    parameter int ADDR_W    = ((NUM_LINES + 3) / 4 > 1) ? $clog2((NUM_LINES + 3) / 4) : 1,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prio_wr_en,
    input  logic [ADDR_W-1:0]     prio_wr_addr,
    input  logic [31:0]           prio_wr_data,
    input  logic [ADDR_W-1:0]     prio_rd_addr,
    output logic [31:0]           prio_rd_data,
    input  logic                  ctrl_wr_en,
    input  logic [31:0]           ctrl_wr_data,
    output logic [31:0]           ctrl_rd_data,
    input  logic [NUM_LINES-1:0]  irq_pend,
    input  logic [NUM_LINES-1:0]  irq_en,
    input  logic                  act_valid,
    input  logic [7:0]            act_prio,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [7:0]            win_prio,
    output logic                  win_preempt
);

    localparam int SPLIT_LSB = 8;

    logic [NUM_LINES-1:0][7:0] fields;
    logic [NUM_LINES-1:0]      req_vec;
    split_t                    split_q;
    cand_t                     best;
    logic                      preempt_c;

    assign req_vec = irq_pend & irq_en;

    prio_field_bank #(
        .NUM_LINES (NUM_LINES),
        .IMPL_BITS (IMPL_BITS),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prio_wr_en),
        .wr_addr (prio_wr_addr),
        .wr_data (prio_wr_data),
        .rd_addr (prio_rd_addr),
        .rd_data (prio_rd_data),
        .fields  (fields)
    );

    prio_min_select #(
        .NUM_LINES (NUM_LINES)
    ) u_select (
        .req    (req_vec),
        .fields (fields),
        .best   (best)
    );

    prio_preempt_cmp u_cmp (
        .cand      (best),
        .split     (split_q),
        .act_valid (act_valid),
        .act_prio  (act_prio),
        .preempt   (preempt_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q <= '0;
        end else if (ctrl_wr_en) begin
            split_q <= ctrl_wr_data[SPLIT_LSB +: 3];
        end
    end

    always_comb begin
        ctrl_rd_data = '0;
        ctrl_rd_data[SPLIT_LSB +: 3] = split_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid   <= 1'b0;
            win_idx     <= '0;
            win_prio    <= '0;
            win_preempt <= 1'b0;
        end else begin
            win_valid   <= best.hit;
            win_idx     <= best.idx[IDX_W-1:0];
            win_prio    <= best.prio;
            win_preempt <= preempt_c;
        end
    end

    // R8
    preempt_needs_win_chk: assert property (@(posedge clk) disable iff (rst)
        win_preempt |-> win_valid);

    // R7
    idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (win_idx == '0 && win_prio == 8'd0 && !win_preempt));

    // R10
    win_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(|req_vec)) |-> win_valid);

    // R6
    win_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (int'(win_idx) < NUM_LINES));

endmodule

// File: tb/grp_prio_arbiter_test.sv
`timescale 1ns/1ps
module grp_prio_arbiter_test;

    localparam int N      = 10;
    localparam int IMPL   = 5;
    localparam int ADDR_W = 2;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prio_wr_en = 1'b0;
    logic [ADDR_W-1:0] prio_wr_addr = '0;
    logic [31:0]       prio_wr_data = '0;
    logic [ADDR_W-1:0] prio_rd_addr = '0;
    logic [31:0]       prio_rd_data;
    logic              ctrl_wr_en = 1'b0;
    logic [31:0]       ctrl_wr_data = '0;
    logic [31:0]       ctrl_rd_data;
    logic [N-1:0]      irq_pend = '0;
    logic [N-1:0]      irq_en = '0;
    logic              act_valid = 1'b0;
    logic [7:0]        act_prio = '0;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [7:0]        win_prio;
    logic              win_preempt;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [N];
    logic [2:0] model_split = 3'd0;
    logic       prev_arb = 1'b0;
    logic [31:0] prev_exp = '0;

    always #4 clk = ~clk;

    grp_prio_arbiter #(.NUM_LINES(N), .IMPL_BITS(IMPL)) uut (
        .clk(clk), .rst(rst),
        .prio_wr_en(prio_wr_en), .prio_wr_addr(prio_wr_addr), .prio_wr_data(prio_wr_data),
        .prio_rd_addr(prio_rd_addr), .prio_rd_data(prio_rd_data),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
        .irq_pend(irq_pend), .irq_en(irq_en), .act_valid(act_valid), .act_prio(act_prio),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio), .win_preempt(win_preempt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] kept_bits();
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = (b >= 8 - IMPL);
        return m;
    endfunction

    function automatic logic [7:0] part_mask(input logic [2:0] g);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = (b > int'(g));
        return m;
    endfunction

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++)
            if (4*a + j < N) w[8*j +: 8] = model[4*a + j];
        return w;
    endfunction

    // packed expectation: {valid, preempt, idx[7:0], prio[7:0]}
    function automatic logic [31:0] exp_arb();
        logic hit = 0; int bi = 0; logic [7:0] bp = 0; logic pre;
        for (int i = 0; i < N; i++)
            if (irq_pend[i] && irq_en[i] && (!hit || model[i] < bp)) begin
                hit = 1; bi = i; bp = model[i];
            end
        if (!hit) pre = 0;
        else if (!act_valid) pre = 1;
        else pre = (bp & part_mask(model_split)) < (act_prio & part_mask(model_split));
        return {14'd0, hit, pre, 8'(bi), bp};
    endfunction

    function automatic logic [31:0] got_arb();
        return {14'd0, win_valid, win_preempt, 8'(win_idx), win_prio};
    endfunction

    task automatic wr_word(input int a, input logic [31:0] d);
        prio_wr_en = 1; prio_wr_addr = ADDR_W'(a); prio_wr_data = d;
        @(posedge clk); #1;
        prio_wr_en = 0;
        for (int j = 0; j < 4; j++)
            if (4*a + j < N) model[4*a + j] = d[8*j +: 8] & kept_bits();
        prev_arb = 0;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        ctrl_wr_en = 1; ctrl_wr_data = d;
        @(posedge clk); #1;
        ctrl_wr_en = 0;
        model_split = d[10:8];
        prev_arb = 0;
    endtask

    task automatic rd_chk(input string req, input int a);
        prio_rd_addr = ADDR_W'(a);
        #1;
        chk(req, prio_rd_data, exp_word(a));
    endtask

    task automatic arb_chk(input string req, input logic [N-1:0] p, input logic [N-1:0] e,
                           input logic av, input logic [7:0] ap);
        logic [31:0] ex;
        irq_pend = p; irq_en = e; act_valid = av; act_prio = ap;
        #2;
        // R10: outputs must not move before the next edge
        if (prev_arb) chk("R10 hold", got_arb(), prev_exp);
        ex = exp_arb();
        @(posedge clk); #1;
        chk(req, got_arb(), ex);
        prev_arb = 1; prev_exp = ex;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 win_valid", {31'd0, win_valid}, 32'd0);
        chk("R1 preempt", {31'd0, win_preempt}, 32'd0);
        chk("R1 ctrl", ctrl_rd_data, 32'd0);
        rd_chk("R1 word0", 0);

        // R2 / R3 packing and low-bit masking
        wr_word(0, 32'h4F2A_1987);
        rd_chk("R2 R3 word0", 0);
        chk("R3 explicit", prio_rd_data, 32'h4828_1880);
        wr_word(1, 32'hFFFF_FFFF);
        rd_chk("R3 word1", 1);
        // R4 lines 10 and 11 absent
        wr_word(2, 32'hFFFF_FFFF);
        rd_chk("R4 word2", 2);
        chk("R4 explicit", prio_rd_data, 32'h0000_F8F8);
        wr_word(3, 32'h1234_5678);
        rd_chk("R4 word3", 3);
        chk("R4 word3 zero", prio_rd_data, 32'd0);

        // R5 split setting
        wr_ctrl(32'hFFFF_FDFF);
        chk("R5 readback", ctrl_rd_data, 32'h0000_0500);

        // R6 tie: lines 1 and 2 same value -> 1
        wr_word(0, 32'h8030_3090);
        wr_word(1, 32'hF0F0_F0F0);
        wr_word(2, 32'h0000_F0F0);
        arb_chk("R6 tie", 10'b00_0000_0110, 10'h3FF, 0, 0);
        chk("R6 tie idx", 32'(win_idx), 32'd1);
        // R7 disabled lower value ignored
        arb_chk("R7 disabled", 10'b00_0000_0111, 10'b11_1111_1001, 0, 0);
        chk("R7 disabled idx", 32'(win_idx), 32'd0);
        arb_chk("R7 none", 10'h3FF, 10'h000, 1, 8'hFF);
        chk("R7 none zero", got_arb(), 32'd0);
        // R9 no active -> preempt
        arb_chk("R9 no active", 10'b00_0000_0010, 10'h3FF, 0, 8'h00);
        // R8 split 5: group bits [7:6]; 0x30 vs 0x20 equal group -> no preempt
        arb_chk("R8 equal group", 10'b00_0000_0010, 10'h3FF, 1, 8'h20);
        chk("R8 equal explicit", {31'd0, win_preempt}, 32'd0);
        arb_chk("R8 lower group", 10'b00_0000_0010, 10'h3FF, 1, 8'h40);
        chk("R8 lower explicit", {31'd0, win_preempt}, 32'd1);
        wr_ctrl(32'h0000_0700);
        arb_chk("R8 split7", 10'b00_0000_0010, 10'h3FF, 1, 8'hFF);
        chk("R8 split7 explicit", {31'd0, win_preempt}, 32'd0);
        wr_ctrl(32'h0000_0000);
        arb_chk("R8 split0", 10'b00_0000_0010, 10'h3FF, 1, 8'h31);
        chk("R8 split0 explicit", {31'd0, win_preempt}, 32'd0);
        arb_chk("R10 repeat", 10'b00_0000_0010, 10'h3FF, 1, 8'h38);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int k = $urandom_range(0, 9);
            if (k < 3) wr_word($urandom_range(0, 3), $urandom());
            else if (k == 3) wr_ctrl($urandom());
            else if (k == 4) rd_chk("R2 R3 R4 random read", $urandom_range(0, 3));
            else arb_chk("R6 R7 R8 R9 random", N'($urandom()), N'($urandom()),
                         1'($urandom()), 8'($urandom()) & 8'hF8);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule